// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small 16-bit multicycle processor. It keeps a 6-bit microstate and holds a 25-bit control word for the datapath. The word comes from a main microcode ROM that is indexed by the microstate. Each step loads the microstate register from one of three sources:

- the next-state field carried in the current control word;
- an opcode dispatch ROM, used at the end of instruction fetch;
- a two-entry branch ROM indexed by the zero flag, used for conditional branches.

The choice is made by two select bits inside the control word itself.

All three ROM images are parameters, so the microprogram is fixed when the block is elaborated. A single-step enable lets the sequencer advance only on the cycles where it is asserted, so a microprogram can be walked one state at a time. The two select bits must never be set together. If a control word does set both, the sequencer holds its state and raises a conflict flag instead of jumping.

Top module: `ucode_sequencer`

## Requirements
- R1: A synchronous active-high reset forces the microstate to 0 at the next rising edge, whatever the step enable is. The control word then shows main ROM entry 0.
- R2: The control word output always equals the main ROM entry of the current microstate. Bit 0 is the LSB of the state-indexed entry, and the image holds entry k at bits [25k+24:25k].
- R3: When control word bits 23 and 24 are both 0, a step loads the microstate from control word bits [5:0].
- R4: When bit 23 is 1 and bit 24 is 0, a step loads the microstate from the dispatch ROM entry indexed by the 3-bit opcode. Entry k sits at image bits [6k+5:6k].
- R5: When bit 24 is 1 and bit 23 is 0, a step loads the microstate from the branch ROM at address {0, zero_flag}. The upper address bit is always 0, so entries 2 and 3 are never used.
- R6: When bits 23 and 24 are both 1, a step leaves the microstate unchanged. In this case `conflict` is 1. `conflict` is 0 for any other control word.
- R7: While `step_en` is 0 and reset is low, the microstate and the control word keep their values. Opcode and zero flag have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance enable for the microstate |
| opcode | input | 3 | Instruction opcode for dispatch |
| zero_flag | input | 1 | Zero result flag for branch decisions |
| ctrl_word | output | 25 | Registered control word of the current microstate |
| conflict | output | 1 | Both next-state select bits set in the current word |

## Verification
The assertions assume that reset is held for at least one edge before any property is relied on. They also assume that `opcode`, `zero_flag` and `step_en` are known at every rising edge.

The bench drives all inputs only on falling edges, so they are stable at each sampling edge. It pulses reset at random. This pulls the sequencer out of the deliberate conflict microstate in its test image, which would otherwise hold it there forever.

The branch ROM image puts a value in the unused upper entries that no reachable path should select.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int STATE_W_D = 6;
  localparam int OP_W_D    = 3;
  localparam int BR_AW_D   = 2;
  // strobe and select bits that sit above the next-state field
  localparam int CTRL_BITS = 19;
  localparam int CW_W_D    = STATE_W_D + CTRL_BITS;

  typedef enum logic [1:0] {
    SRC_FIELD    = 2'b00,
    SRC_DISPATCH = 2'b01,
    SRC_BRANCH   = 2'b10,
    SRC_CONFLICT = 2'b11
  } nsrc_e;

  // Default microprogram: a short fetch (states 0..2) ending in dispatch,
  // four-state execute blocks per opcode, one branch decision state.
  function automatic logic [(1<<STATE_W_D)*CW_W_D-1:0] dflt_main();
    logic [(1<<STATE_W_D)*CW_W_D-1:0] img;
    logic [CW_W_D-1:0] w;
    img = '0;
    for (int s = 0; s < (1<<STATE_W_D); s++) begin
      w = '0;
      w[STATE_W_D-1:0] = ((s & 3) == 3) ? '0 : STATE_W_D'(s + 1);
      w[CW_W_D-3:STATE_W_D] = 17'((s * 613) ^ 17'h0a5a5);
      if (s == 2)  w[CW_W_D-2] = 1'b1;
      if (s == 29) w[CW_W_D-1] = 1'b1;
      img[s*CW_W_D +: CW_W_D] = w;
    end
    return img;
  endfunction

  function automatic logic [(1<<OP_W_D)*STATE_W_D-1:0] dflt_dispatch();
    logic [(1<<OP_W_D)*STATE_W_D-1:0] img;
    for (int k = 0; k < (1<<OP_W_D); k++)
      img[k*STATE_W_D +: STATE_W_D] = STATE_W_D'(8 + 4*k);
    return img;
  endfunction

  function automatic logic [(1<<BR_AW_D)*STATE_W_D-1:0] dflt_branch();
    logic [(1<<BR_AW_D)*STATE_W_D-1:0] img;
    img = '0;
    img[0 +: STATE_W_D]         = STATE_W_D'(30);
    img[STATE_W_D +: STATE_W_D] = STATE_W_D'(0);
    return img;
  endfunction
endpackage

// File: rtl/useq_main_rom.sv
module useq_main_rom #(
  parameter int AW = 6,
  parameter int DW = 25,
  localparam int DEPTH = 1 << AW,
  parameter logic [DEPTH*DW-1:0] IMG = '0
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] dout
);
  // synchronous read with enable: maps to a block RAM initialised as ROM
  always_ff @(posedge clk) begin
    if (rd_en) dout <= IMG[int'(addr)*DW +: DW];
  end

  // R2
  rom_read_chk: assert property (@(posedge clk)
    rd_en |=> dout == IMG[int'($past(addr))*DW +: DW]);

  // R7
  rom_hold_chk: assert property (@(posedge clk)
    !rd_en |=> $stable(dout));
endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel
  import useq_pkg::*;
#(
  parameter int STATE_W = 6,
  parameter int OP_W    = 3,
  parameter int BR_AW   = 2,
  parameter logic [(1<<OP_W)*STATE_W-1:0]  DISP_IMG = '0,
  parameter logic [(1<<BR_AW)*STATE_W-1:0] BR_IMG   = '0
) (
  input  nsrc_e              src,
  input  logic [STATE_W-1:0] cur_state,
  input  logic [STATE_W-1:0] field_state,
  input  logic [OP_W-1:0]    opcode,
  input  logic               zero_flag,
  output logic [STATE_W-1:0] nxt_state,
  output logic               conflict
);
  logic [BR_AW-1:0]   br_addr;
  logic [STATE_W-1:0] disp_entry, br_entry;

  // branch ROM only needs one address bit; wider ROMs get the rest tied low
  generate
    if (BR_AW > 1) begin : g_br_pad
      assign br_addr = {{(BR_AW-1){1'b0}}, zero_flag};
    end else begin : g_br_bit
      assign br_addr = zero_flag;
    end
  endgenerate

  assign disp_entry = DISP_IMG[int'(opcode)*STATE_W +: STATE_W];
  assign br_entry   = BR_IMG[int'(br_addr)*STATE_W +: STATE_W];

  always_comb begin
    conflict = 1'b0;
    unique case (src)
      SRC_FIELD:    nxt_state = field_state;
      SRC_DISPATCH: nxt_state = disp_entry;
      SRC_BRANCH:   nxt_state = br_entry;
      default: begin
        nxt_state = cur_state;
        conflict  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import useq_pkg::*;
#(
  parameter int STATE_W = STATE_W_D,
  parameter int OP_W    = OP_W_D,
  parameter int BR_AW   = BR_AW_D,
  localparam int CW_W   = STATE_W + CTRL_BITS,
  localparam int NSTATE = 1 << STATE_W,
  parameter logic [NSTATE*CW_W-1:0]         MAIN_IMG = dflt_main(),
  parameter logic [(1<<OP_W)*STATE_W-1:0]  DISP_IMG = dflt_dispatch(),
  parameter logic [(1<<BR_AW)*STATE_W-1:0] BR_IMG   = dflt_branch()
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic [OP_W-1:0] opcode,
  input  logic            zero_flag,
  output logic [CW_W-1:0] ctrl_word,
  output logic            conflict
);
  localparam int SEL_DISP_BIT = CW_W - 2;
  localparam int SEL_BR_BIT   = CW_W - 1;

  logic [STATE_W-1:0] cur_q, nxt_s, rd_addr;
  logic [CW_W-1:0]    cw;
  logic               rd_en, conflict_s;
  nsrc_e              src;

  assign src = nsrc_e'({cw[SEL_BR_BIT], cw[SEL_DISP_BIT]});

  useq_next_sel #(
    .STATE_W(STATE_W), .OP_W(OP_W), .BR_AW(BR_AW),
    .DISP_IMG(DISP_IMG), .BR_IMG(BR_IMG)
  ) i_next_sel (
    .src(src),
    .cur_state(cur_q),
    .field_state(cw[STATE_W-1:0]),
    .opcode(opcode),
    .zero_flag(zero_flag),
    .nxt_state(nxt_s),
    .conflict(conflict_s)
  );

  // the ROM is addressed with the state being loaded, so its registered
  // output always lines up with cur_q
  assign rd_addr = rst ? '0 : nxt_s;
  assign rd_en   = rst | step_en;

  useq_main_rom #(.AW(STATE_W), .DW(CW_W), .IMG(MAIN_IMG)) i_main_rom (
    .clk(clk),
    .rd_en(rd_en),
    .addr(rd_addr),
    .dout(cw)
  );

  always_ff @(posedge clk) begin
    if (rst)          cur_q <= '0;
    else if (step_en) cur_q <= nxt_s;
  end

  assign ctrl_word = cw;
  assign conflict  = conflict_s;

  // R1
  rst_state_chk: assert property (@(posedge clk)
    $past(rst) |-> cur_q == '0);

  // R3
  field_next_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && src == SRC_FIELD) |=> cur_q == $past(cw[STATE_W-1:0]));

  // R6
  conflict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && conflict_s) |=> $stable(cur_q));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(cur_q));
endmodule

// File: tb/test_ucode_sequencer.sv
module test_ucode_sequencer;
  function automatic logic [24:0] tb_word(int s);
    logic [24:0] w;
    w = '0;
    w[5:0]  = 6'((s*11 + 5) % 64);
    w[22:6] = 17'(s*1237 + 91);
    if (s % 8 == 2) w[23] = 1'b1;
    if (s % 8 == 6) w[24] = 1'b1;
    if (s == 45) begin w[23] = 1'b1; w[24] = 1'b1; end
    return w;
  endfunction

  function automatic logic [5:0] tb_disp(int op);
    return 6'((op*9 + 1) % 64);
  endfunction

  function automatic logic [5:0] tb_br(int a);
    return (a == 0) ? 6'd45 : (a == 1) ? 6'd17 : 6'd63;
  endfunction

  function automatic logic [64*25-1:0] mk_main();
    logic [64*25-1:0] img;
    for (int s = 0; s < 64; s++) img[s*25 +: 25] = tb_word(s);
    return img;
  endfunction

  function automatic logic [8*6-1:0] mk_disp();
    logic [8*6-1:0] img;
    for (int k = 0; k < 8; k++) img[k*6 +: 6] = tb_disp(k);
    return img;
  endfunction

  function automatic logic [4*6-1:0] mk_br();
    logic [4*6-1:0] img;
    for (int k = 0; k < 4; k++) img[k*6 +: 6] = tb_br(k);
    return img;
  endfunction

  localparam logic [64*25-1:0] MAIN_T = mk_main();
  localparam logic [8*6-1:0]   DISP_T = mk_disp();
  localparam logic [4*6-1:0]   BR_T   = mk_br();

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [2:0]  opcode = '0;
  logic        zero_flag = 1'b0;
  logic [24:0] ctrl_word;
  logic        conflict;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ucode_sequencer #(.MAIN_IMG(MAIN_T), .DISP_IMG(DISP_T), .BR_IMG(BR_T)) i_ucode_sequencer (
    .clk(clk), .rst(rst), .step_en(step_en), .opcode(opcode),
    .zero_flag(zero_flag), .ctrl_word(ctrl_word), .conflict(conflict)
  );

  task automatic check(bit ok, string tag, logic [24:0] act, logic [24:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    int m_state, p_state;
    string p_tag;
    logic [24:0] w;
    p_state = 0;
    p_tag = "R1 reset";
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      m_state = p_state;
      w = tb_word(m_state);
      check(ctrl_word === w, {"R2 word after ", p_tag}, ctrl_word, w);
      check(conflict === (w[23] & w[24]), {"R6 flag after ", p_tag},
            25'(conflict), 25'(w[23] & w[24]));
      rst       = (cyc < 2) || ($urandom_range(0, 39) == 0);
      step_en   = ($urandom_range(0, 3) != 0);
      opcode    = 3'($urandom_range(0, 7));
      zero_flag = 1'($urandom_range(0, 1));
      if (rst) begin
        p_state = 0;  p_tag = "R1 reset";
      end else if (!step_en) begin
        p_state = m_state;  p_tag = "R7 idle";
      end else begin
        case ({w[24], w[23]})
          2'b00: begin p_state = int'(w[5:0]);        p_tag = "R3 field"; end
          2'b01: begin p_state = int'(tb_disp(opcode)); p_tag = "R4 dispatch"; end
          2'b10: begin p_state = int'(tb_br(zero_flag)); p_tag = "R5 branch"; end
          default: begin p_state = m_state;           p_tag = "R6 conflict hold"; end
        endcase
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule